// File: doc/BRIEF.md
# Microcode ALU with Post-Shifter

This block is the arithmetic core of a small microprogrammed stack-machine datapath. It takes two 32-bit operands. The left one always comes from the holding register H. The right one comes from whatever readable register the datapath has placed on the operand bus. A 6-bit function field picks the arithmetic or logic operation. A 2-bit shift field then passes the ALU output through a shifter that sits after it.

The function set is deliberately lopsided. Only the bus operand can be inverted, so negation and subtraction always take the bus value away from H, and the constants -1 and H-1 come out of the same inverter. The zero and negative status bits are taken from the ALU output before the shifter, so that microcode can branch on them in the following cycle. The result and both flags are registered on the rising clock edge. An active-low asynchronous reset clears all three.

Top module: `uprog_alu`

## Requirements
- R1: The function field `funcSel[5:0]` is laid out as {fn[1:0], enH, enBus, invBus, carryIn}, with fn 00=AND, 01=OR, 10=NOT H, 11=ADD. The bus-operand functions are selected by these codes: bus = 6'b010100, negated bus = 6'b110111, bitwise NOT of bus = 6'b010110, bus+1 = 6'b110101.
- R2: H-only functions are selected by these codes: H = 6'b011000, NOT H = 6'b101000, H+1 = 6'b111001.
- R3: Combined functions are selected by these codes: H AND bus = 6'b001100, H OR bus = 6'b011100, H+bus = 6'b111100, H+bus+1 = 6'b111101, H-bus = 6'b111111, H-1 = 6'b111010.
- R4: Constants are selected by these codes: 0 = 6'b000000, 1 = 6'b110001, -1 = 6'b010010.
- R5: The shift field `shiftSel` is laid out as {left8, right1}. Codes 2'b00 and 2'b11 both pass the ALU output through unshifted.
- R6: Code 2'b10 shifts the ALU output left by 8 and fills the low 8 bits with zeros.
- R7: Code 2'b01 shifts the ALU output right by 1 and copies bit 31 into bit 31 (arithmetic shift).
- R8: `zeroFlag` is 1 exactly when all 32 bits of the ALU output are zero. `negFlag` equals bit 31 of the ALU output. Both are taken before the shifter, whatever the shift code.
- R9: `result`, `zeroFlag` and `negFlag` reflect the inputs present at the previous rising clock edge. While `rstN` is low, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hReg | input | 32 | Holding register operand (left input) |
| busIn | input | 32 | Bus operand (right input) |
| funcSel | input | 6 | ALU function field |
| shiftSel | input | 2 | Shifter mode field |
| result | output | 32 | Registered shifted result |
| zeroFlag | output | 1 | Registered zero status of the pre-shift ALU output |
| negFlag | output | 1 | Registered sign of the pre-shift ALU output |

## Verification
The hardest case to reach from the ports is a flag that disagrees with the visible result. This happens when the shifter hides the ALU output that the flags describe. One example is a left shift that pushes every set bit out, so the result is zero while the zero flag stays clear. Another is a right shift of 1, which gives zero while the flag reports non-zero. The stimulus reaches these cases by pairing every function code with every shift code over the edge operands 0, 1, 0x7FFFFFFF and 0x80000000. Seeded random operands then exercise carries and borrows across the whole word.

// File: rtl/uprog_alu_pkg.sv
package uprog_alu_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTH = 2'b10,
    FN_ADD  = 2'b11
  } aluFn_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10
  } shiftMode_e;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    aluFn_e     fn;
    logic       enH;
    logic       enBus;
    logic       invBus;
    logic       carryIn;
    shiftMode_e shift;
  } aluStrobes_t;

endpackage

// File: rtl/uprog_alu_ctrl.sv
module uprog_alu_ctrl
  import uprog_alu_pkg::*;
(
  input  logic [5:0]  funcSel,
  input  logic [1:0]  shiftSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes.fn      = aluFn_e'(funcSel[5:4]);
    strobes.enH     = funcSel[3];
    strobes.enBus   = funcSel[2];
    strobes.invBus  = funcSel[1];
    strobes.carryIn = funcSel[0];
    unique case (shiftSel)
      2'b10:   strobes.shift = SH_LEFT;
      2'b01:   strobes.shift = SH_RIGHT;
      default: strobes.shift = SH_NONE;  // 00 and 11 pass through
    endcase
  end

endmodule

// File: rtl/uprog_alu_dp.sv
module uprog_alu_dp
  import uprog_alu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int LEFT_SHIFT = 8
) (
  input  logic [WIDTH-1:0] hReg,
  input  logic [WIDTH-1:0] busIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] shifted,
  output logic             zeroPre,
  output logic             negPre
);

  localparam int SIGN = WIDTH - 1;

  logic [WIDTH-1:0] leftOp;
  logic [WIDTH-1:0] rightOp;
  logic [WIDTH-1:0] aluOut;

  always_comb begin
    leftOp  = strobes.enH ? hReg : '0;
    rightOp = strobes.enBus ? busIn : '0;
    if (strobes.invBus) rightOp = ~rightOp;
    unique case (strobes.fn)
      FN_AND:  aluOut = leftOp & rightOp;
      FN_OR:   aluOut = leftOp | rightOp;
      FN_NOTH: aluOut = ~leftOp;
      default: aluOut = leftOp + rightOp + {{(WIDTH-1){1'b0}}, strobes.carryIn};
    endcase
  end

  assign zeroPre = (aluOut == '0);
  assign negPre  = aluOut[SIGN];

  always_comb begin
    unique case (strobes.shift)
      SH_LEFT:  shifted = aluOut << LEFT_SHIFT;
      SH_RIGHT: shifted = {aluOut[SIGN], aluOut[SIGN:1]};
      default:  shifted = aluOut;
    endcase
  end

endmodule

// File: rtl/uprog_alu.sv
module uprog_alu
  import uprog_alu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int LEFT_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] hReg,
  input  logic [WIDTH-1:0] busIn,
  input  logic [5:0]       funcSel,
  input  logic [1:0]       shiftSel,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag
);

  aluStrobes_t      strobes;
  logic [WIDTH-1:0] shiftedNext;
  logic             zeroNext;
  logic             negNext;

  uprog_alu_ctrl u_ctrl (
    .funcSel (funcSel),
    .shiftSel(shiftSel),
    .strobes (strobes)
  );

  uprog_alu_dp #(.WIDTH(WIDTH), .LEFT_SHIFT(LEFT_SHIFT)) u_dp (
    .hReg   (hReg),
    .busIn  (busIn),
    .strobes(strobes),
    .shifted(shiftedNext),
    .zeroPre(zeroNext),
    .negPre (negNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      zeroFlag <= 1'b0;
      negFlag  <= 1'b0;
    end else begin
      result   <= shiftedNext;
      zeroFlag <= zeroNext;
      negFlag  <= negNext;
    end
  end

endmodule

// File: rtl/uprog_alu_chk.sv
module uprog_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [5:0]       funcSel,
  input logic [1:0]       shiftSel,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             negFlag
);

  // R5
  pass_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSel == 2'b00 || shiftSel == 2'b11) |=>
      (zeroFlag == (result == '0)) && (negFlag == result[WIDTH-1]));

  // R6
  left_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSel == 2'b10) |=> (result[7:0] == 8'h00));

  // R7
  right_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSel == 2'b01) |=>
      (result[WIDTH-1] == result[WIDTH-2]) && (negFlag == result[WIDTH-1]));

  // R4
  const_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 6'b000000) |=> (zeroFlag && !negFlag && result == '0));

  // R4
  const_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 6'b110001 && shiftSel == 2'b00) |=> (result == 1 && !zeroFlag));

  // R8
  neg_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    negFlag |-> !zeroFlag);

endmodule

bind uprog_alu uprog_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .funcSel (funcSel),
  .shiftSel(shiftSel),
  .result  (result),
  .zeroFlag(zeroFlag),
  .negFlag (negFlag)
);

// File: tb/tb_uprog_alu.sv
module tb_uprog_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_OPS    = 16;
  localparam int NUM_RAND   = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hReg = '0;
  logic [31:0] busIn = '0;
  logic [5:0]  funcSel = '0;
  logic [1:0]  shiftSel = '0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        negFlag;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uprog_alu dut (
    .clk(clk), .rstN(rstN), .hReg(hReg), .busIn(busIn),
    .funcSel(funcSel), .shiftSel(shiftSel),
    .result(result), .zeroFlag(zeroFlag), .negFlag(negFlag)
  );

  function automatic logic [5:0] opCode(int idx);
    case (idx)
      0: return 6'b010100;  1: return 6'b110111;  2: return 6'b010110;
      3: return 6'b110101;  4: return 6'b011000;  5: return 6'b101000;
      6: return 6'b111001;  7: return 6'b001100;  8: return 6'b011100;
      9: return 6'b111100; 10: return 6'b111101; 11: return 6'b111111;
     12: return 6'b111010; 13: return 6'b000000; 14: return 6'b110001;
      default: return 6'b010010;
    endcase
  endfunction

  function automatic string opReq(int idx);
    if (idx < 4) return "R1";
    if (idx < 7) return "R2";
    if (idx < 13) return "R3";
    return "R4";
  endfunction

  function automatic logic [31:0] refAlu(int idx, logic [31:0] h, logic [31:0] b);
    case (idx)
      0: return b;          1: return 32'd0 - b;   2: return ~b;
      3: return b + 1;      4: return h;           5: return ~h;
      6: return h + 1;      7: return h & b;       8: return h | b;
      9: return h + b;     10: return h + b + 1;  11: return h - b;
     12: return h - 1;     13: return 32'd0;      14: return 32'd1;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] refShift(logic [31:0] v, logic [1:0] s);
    if (s == 2'b10) return {v[23:0], 8'h00};
    if (s == 2'b01) return {v[31], v[31:1]};
    return v;
  endfunction

  function automatic string shReq(logic [1:0] s);
    if (s == 2'b10) return "R6";
    if (s == 2'b01) return "R7";
    return "R5";
  endfunction

  function automatic logic [31:0] edgeVal(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      default: return 32'h8000_0000;
    endcase
  endfunction

  task automatic compare(string req, logic [31:0] expRes, logic expZ, logic expN);
    compared++;
    if (result !== expRes || zeroFlag !== expZ || negFlag !== expN) begin
      mismatched++;
      $display("FAIL %s: result=%h z=%b n=%b expected result=%h z=%b n=%b",
               req, result, zeroFlag, negFlag, expRes, expZ, expN);
    end
  endtask

  // Drive one vector, wait for the capturing edge, then check (R8, R9).
  task automatic runVec(int idx, logic [1:0] s, logic [31:0] h, logic [31:0] b);
    logic [31:0] raw;
    @(negedge clk);
    hReg = h; busIn = b; funcSel = opCode(idx); shiftSel = s;
    raw = refAlu(idx, h, b);
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare({opReq(idx), "/", shReq(s), "/R8/R9"}, refShift(raw, s),
            raw == 32'd0, raw[31]);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #(CLK_PERIOD*2 + 1);
    compare("R9 reset", 32'd0, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int op = 0; op < NUM_OPS; op++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            runVec(op, 2'(s), edgeVal(i), edgeVal(j));
        for (int r = 0; r < NUM_RAND; r++)
          runVec(op, 2'(s), $urandom, $urandom);
      end
    end

    // R8: left shift pushes all set bits out while the zero flag stays clear
    runVec(4, 2'b10, 32'hFF00_0000, 32'h0);
    // R8: right shift of 1 gives zero, flag reports non-zero
    runVec(4, 2'b01, 32'h0000_0001, 32'h0);

    // R9: reset during operation clears the outputs
    @(negedge clk);
    rstN = 1'b0;
    #(CLK_PERIOD/4);
    compare("R9 async clear", 32'd0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule